// File: doc/BRIEF.md
# Vector Constant Upload Unpacker

This block takes 32-bit words written by a host into a constant-upload port and builds four-component vector constants from them, each component a 24-bit float (1 sign bit, 7 exponent bits biased by 63, 16 mantissa bits). Finished vectors are stored in a 96-entry constant register file. A separate index write picks the first entry to fill and the input format. After each completed vector the entry index advances by one, so a run of vectors can be streamed without rewriting the index.

There are two input formats. In the packed format, three words carry the four 24-bit components in reversed order. In the wide format, four IEEE single-precision words each yield one component through a format conversion. The conversion re-biases the exponent, truncates the mantissa, saturates large values to infinity, flushes small values to signed zero and keeps NaNs as NaNs. The register file has one combinational read port for the shader datapath. A data word sent while the index lies outside the file is dropped and raises a sticky error flag.

Top module: `vconst_loader`

## Requirements
- R1: After synchronous active-low reset, the entry index is 0, the format is packed, no words are buffered, `err_flag` is 0 and every entry reads as zero.
- R2: An index write (`idx_wr`) loads the entry index from `idx_data[7:0]` and selects wide format when `idx_data[31]` is 1 and packed format when it is 0. It also discards any partly gathered words.
- R3: Packed format: a vector completes on its third word. With words a, b, c in arrival order, x = c[23:0], y = {b[15:0], c[31:24]}, z = {a[7:0], b[31:16]}, w = a[31:8].
- R4: Wide format: a vector completes on its fourth word. x is converted from the fourth word, y from the third, z from the second and w from the first.
- R5: For a single-precision input with biased exponent e where 65 <= e <= 190, the converted value is {sign, e-64 in 7 bits, mantissa[22:7]}.
- R6: An input with e >= 191 and e < 255, or an infinity (e = 255, mantissa 0), converts to {sign, 7'h7F, 16'h0000}.
- R7: An input with e <= 64 (including zero and denormals) converts to {sign, 23'b0}.
- R8: A NaN input (e = 255, mantissa nonzero) converts to {sign, 7'h7F, 1'b1, mantissa[21:7]}.
- R9: A completed vector is written to the current entry. The index then rises by one and the word count returns to zero, so the next vector lands in the next entry.
- R10: A data word taken while the index is 96 or more is discarded: no entry changes, no word is buffered, and `err_flag` goes to 1 and stays 1 until reset.
- R11: If `idx_wr` and `word_wr` are both high in the same cycle, the index write takes effect and the data word is dropped.
- R12: `rd_vec` shows the entry selected by `rd_idx` in the same cycle, with x in [23:0], y in [47:24], z in [71:48] and w in [95:72]. For `rd_idx` of 96 or more it reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| idx_wr | input | 1 | Index register write strobe |
| idx_data | input | 32 | Index word: [7:0] start entry, [31] wide format |
| word_wr | input | 1 | Data word write strobe |
| word_data | input | 32 | Data word |
| rd_idx | input | 7 | Read port entry select |
| rd_vec | output | 96 | Read port vector {w, z, y, x} |
| err_flag | output | 1 | Sticky out-of-range write error |

## Verification
The bench checks the packed bit mapping with words whose fields are all different. If the design swaps a word or a byte, the wrong component shows up at a known position. It drives every exponent boundary (64, 65, 190, 191, 255) and NaNs whose top mantissa bits are zero. An off-by-one in the thresholds, or a NaN that collapses into infinity, then gives a visibly wrong code. It sends a short partial burst followed by a new index write, and an index write in the same cycle as a data word. A design that kept stale words would shift every later component by one word. The last vector goes into entry 95 and further words follow it. A design without the range guard would write past the end, wrap to entry 0, or fail to raise the error flag.

// File: rtl/vcl_pkg.sv
// Shared types and sizes for the vector constant loader.
// Assumes a 4-lane vector of 24-bit floats held in a 96-bit word.
package vcl_pkg;
    localparam int WORD_W  = 32;
    localparam int COMP_W  = 24;
    localparam int NCOMP   = 4;
    localparam int VEC_W   = COMP_W * NCOMP;
    localparam int DEPTH   = 96;
    localparam int IDX_W   = 8;
    localparam int RD_W    = 7;
    localparam int HELD    = 3;
    localparam int CNT_W   = 2;

    typedef enum logic {
        FMT_PACKED = 1'b0,
        FMT_WIDE   = 1'b1
    } fmt_e;
endpackage

// File: rtl/vcl_f32_to_f24.sv
// Converts one IEEE single-precision value to a 24-bit float
// (1 sign, 7 exponent with bias 63, 16 mantissa). Purely combinational.
// Assumes truncation of the mantissa; out-of-range values saturate or flush.
module vcl_f32_to_f24 (
    input  logic [31:0] f_in,
    output logic [23:0] f_out
);
    localparam logic [7:0] BIAS_GAP = 8'd64;   // 127 - 63
    localparam logic [7:0] E_MAX    = 8'hFF;
    localparam logic [7:0] E_SAT    = 8'd191;  // rebiased exponent would reach 127

    logic       sgn;
    logic [7:0] exp_in;
    logic [22:0] man;
    logic [7:0] exp_out;

    // Classify the input and build the narrow encoding
    always_comb begin
        sgn     = f_in[31];
        exp_in  = f_in[30:23];
        man     = f_in[22:0];
        exp_out = exp_in - BIAS_GAP;
        if (exp_in == E_MAX) begin
            if (man != 23'd0) f_out = {sgn, 7'h7F, 1'b1, man[21:7]};
            else              f_out = {sgn, 7'h7F, 16'h0000};
        end else if (exp_in >= E_SAT) begin
            f_out = {sgn, 7'h7F, 16'h0000};
        end else if (exp_in <= BIAS_GAP) begin
            f_out = {sgn, 23'd0};
        end else begin
            f_out = {sgn, exp_out[6:0], man[22:7]};
        end
    end
endmodule

// File: rtl/vcl_word_buffer.sv
// Holds the data words of the vector being gathered and counts them.
// Flags completion when the final word of the current format arrives;
// that word is not stored, it is passed straight to the assembler.
// Assumes push is only raised for words that may be accepted.
module vcl_word_buffer #(
    parameter int WORD_W = vcl_pkg::WORD_W,
    parameter int HELD   = vcl_pkg::HELD,
    parameter int CNT_W  = vcl_pkg::CNT_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  vcl_pkg::fmt_e                fmt,
    input  logic [WORD_W-1:0]            din,
    output logic [HELD-1:0][WORD_W-1:0]  held,
    output logic [CNT_W-1:0]             cnt,
    output logic                         commit
);
    localparam logic [CNT_W-1:0] LAST_PACKED = CNT_W'(2);
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(3);

    logic [CNT_W-1:0] last_slot;

    // Pick the count at which the incoming word completes a vector
    always_comb begin
        last_slot = (fmt == vcl_pkg::FMT_WIDE) ? LAST_WIDE : LAST_PACKED;
        commit    = push && (cnt == last_slot);
    end

    // Word counter: cleared by index writes and on completion
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (commit)  cnt <= '0;
        else if (push)    cnt <= cnt + CNT_W'(1);
    end

    genvar s;
    generate
        for (s = 0; s < HELD; s++) begin : g_slot
            // Capture the word into its arrival slot
            always_ff @(posedge clk) begin
                if (!rst_n)                                 held[s] <= '0;
                else if (push && !commit && !clr &&
                         cnt == CNT_W'(s))                  held[s] <= din;
            end
        end
    endgenerate
endmodule

// File: rtl/vcl_assembler.sv
// Builds a 96-bit vector {w,z,y,x} from the held words plus the final word.
// Packed: three words carry four 24-bit fields in reversed order.
// Wide: four single-precision words, last word -> x, first word -> w.
module vcl_assembler #(
    parameter int WORD_W = vcl_pkg::WORD_W,
    parameter int HELD   = vcl_pkg::HELD,
    parameter int COMP_W = vcl_pkg::COMP_W,
    parameter int NCOMP  = vcl_pkg::NCOMP,
    parameter int VEC_W  = vcl_pkg::VEC_W
) (
    input  vcl_pkg::fmt_e                fmt,
    input  logic [HELD-1:0][WORD_W-1:0]  held,
    input  logic [WORD_W-1:0]            newest,
    output logic [VEC_W-1:0]             vec
);
    logic [NCOMP-1:0][WORD_W-1:0] lane_src;
    logic [VEC_W-1:0]             wide_vec;
    logic [VEC_W-1:0]             packed_vec;

    // Order the wide-format words so lane 0 (x) takes the newest word
    always_comb begin
        lane_src[0] = newest;
        for (int l = 1; l < NCOMP; l++) lane_src[l] = held[HELD - l];
    end

    genvar l;
    generate
        for (l = 0; l < NCOMP; l++) begin : g_lane
            vcl_f32_to_f24 u_cvt (
                .f_in  (lane_src[l]),
                .f_out (wide_vec[l*COMP_W +: COMP_W])
            );
        end
    endgenerate

    // Split the three packed words into four fields
    always_comb begin
        packed_vec[0*COMP_W +: COMP_W] = newest[23:0];
        packed_vec[1*COMP_W +: COMP_W] = {held[1][15:0], newest[31:24]};
        packed_vec[2*COMP_W +: COMP_W] = {held[0][7:0], held[1][31:16]};
        packed_vec[3*COMP_W +: COMP_W] = held[0][31:8];
    end

    // Select the result for the active format
    always_comb vec = (fmt == vcl_pkg::FMT_WIDE) ? wide_vec : packed_vec;
endmodule

// File: rtl/vcl_regfile.sv
// Constant register file: one write port, one combinational read port.
// Assumes the writer only asserts we with waddr below DEPTH.
// Reads of entries at or beyond DEPTH return zero.
module vcl_regfile #(
    parameter int DEPTH = vcl_pkg::DEPTH,
    parameter int VEC_W = vcl_pkg::VEC_W,
    parameter int WA_W  = vcl_pkg::IDX_W,
    parameter int RA_W  = vcl_pkg::RD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WA_W-1:0]   waddr,
    input  logic [VEC_W-1:0]  wdata,
    input  logic [RA_W-1:0]   raddr,
    output logic [VEC_W-1:0]  rdata
);
    logic [VEC_W-1:0] mem [DEPTH];

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_ent
            // Clear on reset, load on a matching write
            always_ff @(posedge clk) begin
                if (!rst_n)                            mem[i] <= '0;
                else if (we && waddr == WA_W'(i))      mem[i] <= wdata;
            end
        end
    endgenerate

    // Combinational read with an out-of-range guard
    always_comb begin
        rdata = '0;
        for (int k = 0; k < DEPTH; k++)
            if (raddr == RA_W'(k)) rdata = mem[k];
    end
endmodule

// File: rtl/vconst_loader.sv
// Top of the vector constant loader. Holds the entry index, the format
// and the sticky error flag; routes data words to the buffer, the
// assembled vector to the register file. Index writes win over data words.
module vconst_loader #(
    parameter int WORD_W = vcl_pkg::WORD_W,
    parameter int VEC_W  = vcl_pkg::VEC_W,
    parameter int DEPTH  = vcl_pkg::DEPTH,
    parameter int IDX_W  = vcl_pkg::IDX_W,
    parameter int RD_W   = vcl_pkg::RD_W,
    parameter int HELD   = vcl_pkg::HELD,
    parameter int CNT_W  = vcl_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic [WORD_W-1:0] idx_data,
    input  logic              word_wr,
    input  logic [WORD_W-1:0] word_data,
    input  logic [RD_W-1:0]   rd_idx,
    output logic [VEC_W-1:0]  rd_vec,
    output logic              err_flag
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

    logic [IDX_W-1:0]             cur_idx;
    vcl_pkg::fmt_e                fmt_sel;
    logic                         take_word;
    logic                         in_range;
    logic                         buf_push;
    logic                         wr_commit;
    logic [CNT_W-1:0]             word_cnt;
    logic [HELD-1:0][WORD_W-1:0]  held_words;
    logic [VEC_W-1:0]             new_vec;

    // Decide whether the data word is stored or rejected
    always_comb begin
        take_word = word_wr && !idx_wr;
        in_range  = cur_idx < LIMIT;
        buf_push  = take_word && in_range;
    end

    // Entry index and format: loaded by index writes, stepped on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx <= '0;
            fmt_sel <= vcl_pkg::FMT_PACKED;
        end else if (idx_wr) begin
            cur_idx <= idx_data[IDX_W-1:0];
            fmt_sel <= vcl_pkg::fmt_e'(idx_data[WORD_W-1]);
        end else if (wr_commit) begin
            cur_idx <= cur_idx + IDX_W'(1);
        end
    end

    // Sticky error on data words aimed past the end of the file
    always_ff @(posedge clk) begin
        if (!rst_n)                     err_flag <= 1'b0;
        else if (take_word && !in_range) err_flag <= 1'b1;
    end

    vcl_word_buffer #(.WORD_W(WORD_W), .HELD(HELD), .CNT_W(CNT_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (idx_wr),
        .push   (buf_push),
        .fmt    (fmt_sel),
        .din    (word_data),
        .held   (held_words),
        .cnt    (word_cnt),
        .commit (wr_commit)
    );

    vcl_assembler #(.WORD_W(WORD_W), .HELD(HELD), .VEC_W(VEC_W)) u_asm (
        .fmt    (fmt_sel),
        .held   (held_words),
        .newest (word_data),
        .vec    (new_vec)
    );

    vcl_regfile #(.DEPTH(DEPTH), .VEC_W(VEC_W), .WA_W(IDX_W), .RA_W(RD_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_commit),
        .waddr (cur_idx),
        .wdata (new_vec),
        .raddr (rd_idx),
        .rdata (rd_vec)
    );
endmodule

// File: rtl/vcl_checker.sv
// Protocol checks for vconst_loader, bound to its internal state nets.
module vcl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        idx_wr,
    input logic [31:0] idx_data,
    input logic        word_wr,
    input logic        err_flag,
    input logic        wr_commit,
    input logic [7:0]  cur_idx,
    input logic [1:0]  word_cnt,
    input logic        fmt_wide
);
    // Index write loads the index and empties the buffer
    a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (cur_idx == $past(idx_data[7:0])) && (word_cnt == 2'd0));

    // Index write selects the format from bit 31
    a_r2_format_load: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (fmt_wide == $past(idx_data[31])));

    // Buffered count never reaches the completing word's slot
    a_r3_cnt_limit: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_wide ? (word_cnt <= 2'd3) : (word_cnt <= 2'd2));

    // A completed vector advances the index by one and clears the count
    a_r9_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> (cur_idx == $past(cur_idx) + 8'd1) && (word_cnt == 2'd0));

    // No write ever targets an entry past the end
    a_r10_no_oob_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> (cur_idx < 8'd96));

    // A rejected word raises the flag
    a_r10_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr && !idx_wr && cur_idx >= 8'd96) |=> err_flag);

    // The flag stays up
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // A simultaneous data word never completes a vector
    a_r11_idx_priority: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |-> !wr_commit);
endmodule

bind vconst_loader vcl_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .idx_data  (idx_data),
    .word_wr   (word_wr),
    .err_flag  (err_flag),
    .wr_commit (wr_commit),
    .cur_idx   (cur_idx),
    .word_cnt  (word_cnt),
    .fmt_wide  (fmt_sel)
);

// File: tb/vconst_loader_tb_top.sv
`timescale 1ns/1ps
module vconst_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_wr = 1'b0;
    logic [31:0] idx_data = '0;
    logic        word_wr = 1'b0;
    logic [31:0] word_data = '0;
    logic [6:0]  rd_idx = '0;
    logic [95:0] rd_vec;
    logic        err_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference state
    logic [95:0] m_mem [96];
    logic [7:0]  m_idx;
    logic        m_wide;
    int          m_cnt;
    logic [31:0] m_buf [4];
    logic        m_err;

    always #2 clk = ~clk;

    vconst_loader dut_i (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_data(idx_data),
        .word_wr(word_wr), .word_data(word_data), .rd_idx(rd_idx),
        .rd_vec(rd_vec), .err_flag(err_flag)
    );

    function automatic logic [23:0] to_f24(input logic [31:0] f);
        logic [7:0] e;
        logic [7:0] ne;
        e = f[30:23];
        ne = e - 8'd64;
        if (e == 8'd255 && f[22:0] != 0) return {f[31], 7'h7F, 1'b1, f[21:7]}; // R8
        if (e >= 8'd191)                 return {f[31], 7'h7F, 16'h0};        // R6
        if (e <= 8'd64)                  return {f[31], 23'h0};               // R7
        return {f[31], ne[6:0], f[22:7]};                                     // R5
    endfunction

    function automatic logic [95:0] build_vec(input logic wide);
        logic [23:0] x, y, z, w;
        if (wide) begin
            x = to_f24(m_buf[3]); y = to_f24(m_buf[2]);
            z = to_f24(m_buf[1]); w = to_f24(m_buf[0]);
        end else begin
            x = m_buf[2][23:0];
            y = {m_buf[1][15:0], m_buf[2][31:24]};
            z = {m_buf[0][7:0], m_buf[1][31:16]};
            w = m_buf[0][31:8];
        end
        return {w, z, y, x};
    endfunction

    task automatic model_step(input logic iw, input logic [31:0] id,
                              input logic ww, input logic [31:0] wd);
        if (iw) begin
            m_idx = id[7:0]; m_wide = id[31]; m_cnt = 0;
        end else if (ww) begin
            if (m_idx >= 8'd96) m_err = 1'b1;
            else begin
                m_buf[m_cnt] = wd;
                m_cnt++;
                if (m_cnt == (m_wide ? 4 : 3)) begin
                    m_mem[m_idx] = build_vec(m_wide);
                    m_idx = m_idx + 8'd1;
                    m_cnt = 0;
                end
            end
        end
    endtask

    task automatic drive(input logic iw, input logic [31:0] id,
                         input logic ww, input logic [31:0] wd);
        @(negedge clk);
        idx_wr = iw; idx_data = id; word_wr = ww; word_data = wd;
        @(posedge clk);
        #1;
        idx_wr = 1'b0; word_wr = 1'b0;
        model_step(iw, id, ww, wd);
    endtask

    task automatic set_idx(input logic [31:0] id);
        drive(1'b1, id, 1'b0, '0);
    endtask

    task automatic put(input logic [31:0] wd);
        drive(1'b0, '0, 1'b1, wd);
    endtask

    task automatic chk_vec(input int e, input logic [95:0] exp_v, input string req);
        @(negedge clk);
        rd_idx = 7'(e);
        #0.5;
        checks++;
        if (rd_vec !== exp_v) begin
            errors++;
            $display("FAIL %s entry %0d: got %h expected %h", req, e, rd_vec, exp_v);
        end
    endtask

    task automatic chk_err(input logic exp_e, input string req);
        @(negedge clk);
        checks++;
        if (err_flag !== exp_e) begin
            errors++;
            $display("FAIL %s err_flag: got %b expected %b", req, err_flag, exp_e);
        end
    endtask

    function automatic logic [31:0] rand_f32();
        logic [7:0] e;
        case ($urandom_range(0, 7))
            0: e = 8'd0;
            1: e = 8'd64;
            2: e = 8'd65;
            3: e = 8'd190;
            4: e = 8'd191;
            5: e = 8'd255;
            default: e = 8'($urandom_range(0, 255));
        endcase
        return {1'($urandom_range(0, 1)), e, 23'($urandom)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 96; i++) m_mem[i] = '0;
        m_idx = '0; m_wide = 1'b0; m_cnt = 0; m_err = 1'b0;
        for (int i = 0; i < 4; i++) m_buf[i] = '0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk_err(1'b0, "R1");
        chk_vec(0, '0, "R1");
        chk_vec(95, '0, "R1");

        // R3: packed mapping with distinct fields
        set_idx(32'h0000_0005);
        put(32'hA1A2_A3A4); put(32'hB1B2_B3B4); put(32'hC1C2_C3C4);
        chk_vec(5, {24'hA1A2A3, 24'hA4B1B2, 24'hB3B4C1, 24'hC2C3C4}, "R3");

        // R4, R5: wide order and normal conversion
        set_idx(32'h8000_000A);
        put(32'h3F80_0000); put(32'h4000_0000); put(32'hBF00_0000); put(32'h4040_0000);
        chk_vec(10, {24'h3F0000, 24'h400000, 24'hBE0000, 24'h408000}, "R4");

        // R5, R6: exponent boundaries 65, 190, 191, infinity
        set_idx(32'h8000_000B);
        put(32'h2080_0000); put(32'h5F7F_FFFF); put(32'h5F80_0000); put(32'hFF80_0000);
        chk_vec(11, {24'h010000, 24'h7EFFFF, 24'h7F0000, 24'hFF0000}, "R6");

        // R7, R8: flush to signed zero, NaN kept
        put(32'h2000_0000); put(32'hA000_0000); put(32'h7FC0_0001); put(32'hFF80_0001);
        chk_vec(12, {24'h000000, 24'h800000, 24'h7F8000, 24'hFF8000}, "R8");

        // R9: consecutive vectors fill consecutive entries
        set_idx(32'h0000_0014);
        for (int v = 0; v < 6; v++) put($urandom);
        chk_vec(20, m_mem[20], "R9");
        chk_vec(21, m_mem[21], "R9");
        chk_vec(22, '0, "R9");

        // R2: partial burst discarded by a new index write
        set_idx(32'h0000_001E);
        put(32'h1111_1111); put(32'h2222_2222);
        set_idx(32'h0000_001E);
        put(32'h3333_3333); put(32'h4444_4444); put(32'h5555_5555);
        chk_vec(30, {24'h333333, 24'h334444, 24'h444455, 24'h555555}, "R2");
        chk_vec(31, '0, "R2");

        // R11: simultaneous index and data write
        drive(1'b1, 32'h0000_0028, 1'b1, 32'hDEAD_BEEF);
        put(32'h0102_0304); put(32'h0506_0708); put(32'h090A_0B0C);
        chk_vec(40, m_mem[40], "R11");
        chk_vec(41, '0, "R11");

        // R10: last entry, then writes past the end
        set_idx(32'h0000_005F);
        put(32'h7777_7777); put(32'h8888_8888); put(32'h9999_9999);
        chk_vec(95, m_mem[95], "R10");
        chk_err(1'b0, "R10");
        put(32'hCAFE_F00D); put(32'hCAFE_F00D); put(32'hCAFE_F00D);
        chk_err(1'b1, "R10");
        chk_vec(0, '0, "R10");
        chk_vec(95, m_mem[95], "R10");

        // R12: reads beyond the file return zero
        chk_vec(96, '0, "R12");
        chk_vec(127, '0, "R12");

        // R10: sticky across an in-range index write
        set_idx(32'h0000_00C8);
        put(32'h1234_5678);
        set_idx(32'h0000_0000);
        chk_err(1'b1, "R10");

        // Random mix, R2..R11
        for (int n = 0; n < 600; n++) begin
            int sel;
            sel = $urandom_range(0, 19);
            if (sel == 0)
                set_idx({1'($urandom_range(0, 1)), 23'd0, 8'($urandom_range(0, 99))});
            else if (sel == 1)
                drive(1'b1, {1'($urandom_range(0, 1)), 23'd0, 8'($urandom_range(0, 95))},
                      1'b1, $urandom);
            else
                put(m_wide ? rand_f32() : $urandom);
        end
        for (int e = 0; e < 96; e++) chk_vec(e, m_mem[e], "R12");
        chk_err(m_err, "R10");

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule